// File: doc/BRIEF.md
# Receive Byte Queue with Error-Tagged Line Interrupts

This block sits between a serial receiver's shifter and the register file of a UART. Each byte the shifter completes is written into a 16-entry queue together with three error tags: parity, framing and break. The host reads bytes out in arrival order through a data-read strobe. While a byte waits at the head of the queue, its data and tags are visible on the output pins.

Errors are reported when the host reaches the bad byte, not when the byte arrives. The line-status interrupt is raised when the head entry carries an error or when an incoming byte was lost to a full queue. Separately, a summary error flag stays up while any tagged byte remains anywhere in the queue.

The block also watches a set of modem control inputs and latches a change flag for each one. It raises a data interrupt once the fill level reaches a selectable trigger. A fixed priority folds the three interrupt sources into a single identifier.

Top module: `rx_err_queue`

## Requirements
- R1: While `rstN` is low the queue is emptied: `level` is 0, `rdByte` and `headErr` are 0, `errSummary`, `overrun` and `modemDelta` are 0, every interrupt output is 0 and `irqId` is 0.
- R2: A write with `wrValid` high stores `wrByte` and `wrErr` at the tail. `rdByte` and `headErr` show the oldest stored entry. A `rdData` pulse removes that entry. `wrErr` bit 0 is parity, bit 1 is framing and bit 2 is break.
- R3: `errSummary` is 1 exactly while at least one stored entry has a nonzero error tag, wherever that entry sits in the queue.
- R4: With `enLine` high, `irqLine` is 1 while the head entry has a nonzero tag that has not been acknowledged, or while `overrun` is 1. An errored entry behind the head does not raise it.
- R5: A `rdLsr` pulse drops `irqLine` on the next cycle, even though the same errored entry stays at the head. The next errored entry to reach the head raises `irqLine` again.
- R6: A write while 16 entries are stored is discarded and sets `overrun`. `overrun` stays set until a `rdLsr` pulse clears it.
- R7: With `enData` high, `irqData` is 1 while `level` is at least the trigger count selected by `trigSel`: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R8: A change on any bit of `modemIn` relative to the previous cycle sets the matching `modemDelta` bit one cycle later. The bit holds until a `rdMsr` pulse clears it. With `enModem` high, `irqModem` is 1 while any delta bit is set.
- R9: `irqId` encodes the highest-priority pending interrupt: 1 for line status, then 2 for received data, then 3 for modem status, and 0 when none is pending.
- R10: A `rdData` pulse while the queue is empty has no effect: `level` stays 0 and the next stored byte is returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset and flush |
| wrValid | input | 1 | Write strobe from the receive shifter |
| wrByte | input | 8 | Received byte |
| wrErr | input | 3 | Error tags: bit0 parity, bit1 framing, bit2 break |
| rdData | input | 1 | Data register read, pops the head entry |
| rdLsr | input | 1 | Line status read strobe |
| rdMsr | input | 1 | Modem status read strobe |
| trigSel | input | 2 | Data trigger select (1, 4, 8, 14 bytes) |
| enLine | input | 1 | Line status interrupt enable |
| enData | input | 1 | Data interrupt enable |
| enModem | input | 1 | Modem status interrupt enable |
| modemIn | input | 4 | Modem control inputs |
| rdByte | output | 8 | Head byte, 0 when empty |
| headErr | output | 3 | Head error tags, 0 when empty |
| level | output | 5 | Number of stored entries |
| errSummary | output | 1 | Some stored entry carries an error |
| overrun | output | 1 | Sticky write-dropped flag |
| modemDelta | output | 4 | Latched per-input change flags |
| irqLine | output | 1 | Line status interrupt |
| irqData | output | 1 | Data trigger interrupt |
| irqModem | output | 1 | Modem status interrupt |
| irqId | output | 2 | Prioritised interrupt identifier |

## Verification
The hardest situation to reach is an errored byte arriving behind clean entries and then moving up to the head. In that situation the summary flag must already be set while the line interrupt is still quiet. The stimulus loads a clean, clean, parity, clean, framing, clean sequence through a vector table. It then pops entry by entry and acknowledges with a status read while the parity byte still sits at the head. Overflow is reached by filling all sixteen slots across the trigger thresholds and then pushing one more byte. Draining afterwards shows the dropped byte never entered.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Strobes the control issues to the storage datapath each cycle.
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  // Line interrupt identifier codes, highest priority first.
  localparam logic [1:0] ID_NONE  = 2'd0;
  localparam logic [1:0] ID_LINE  = 2'd1;
  localparam logic [1:0] ID_DATA  = 2'd2;
  localparam logic [1:0] ID_MODEM = 2'd3;
endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strobe,
  input  logic [WIDTH-1:0] wrWord,
  output logic [WIDTH-1:0] headWord,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headWord = mem[rdPtr];
  assign full     = (level == CNT_W'(DEPTH));
  assign empty    = (level == '0);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ERR_W = 3,
  parameter int MODEM_W = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [ERR_W-1:0]   wrErr,
  input  logic               rdData,
  input  logic               rdLsr,
  input  logic               rdMsr,
  input  logic [1:0]         trigSel,
  input  logic               enLine,
  input  logic               enData,
  input  logic               enModem,
  input  logic [MODEM_W-1:0] modemIn,
  input  logic [CNT_W-1:0]   level,
  input  logic               full,
  input  logic               empty,
  input  logic [ERR_W-1:0]   headErr,
  output qStrobe_t           strobe,
  output logic               errSummary,
  output logic               overrun,
  output logic [MODEM_W-1:0] modemDelta,
  output logic               irqLine,
  output logic               irqData,
  output logic               irqModem,
  output logic [1:0]         irqId
);
  localparam logic [CNT_W-1:0] TRIG_Q = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] TRIG_H = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TRIG_F = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0]   errCount;
  logic               headAck;
  logic [MODEM_W-1:0] modemPrev;
  logic               primed;
  logic [CNT_W-1:0]   trigLevel;
  logic               pushErr;
  logic               popErr;

  assign strobe.push = wrValid && !full;
  assign strobe.pop  = rdData && !empty;
  assign pushErr     = strobe.push && (|wrErr);
  assign popErr      = strobe.pop && (|headErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCount <= '0;
      overrun  <= 1'b0;
      headAck  <= 1'b0;
    end else begin
      case ({pushErr, popErr})
        2'b10:   errCount <= errCount + 1'b1;
        2'b01:   errCount <= errCount - 1'b1;
        default: errCount <= errCount;
      endcase
      if (wrValid && full)  overrun <= 1'b1;
      else if (rdLsr)       overrun <= 1'b0;
      if (strobe.pop)               headAck <= 1'b0;
      else if (rdLsr && !empty)     headAck <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modemPrev  <= '0;
      primed     <= 1'b0;
      modemDelta <= '0;
    end else begin
      modemPrev <= modemIn;
      primed    <= 1'b1;
      for (int i = 0; i < MODEM_W; i++) begin
        if (primed && (modemIn[i] != modemPrev[i])) modemDelta[i] <= 1'b1;
        else if (rdMsr)                             modemDelta[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (trigSel)
      2'd0:    trigLevel = CNT_W'(1);
      2'd1:    trigLevel = TRIG_Q;
      2'd2:    trigLevel = TRIG_H;
      default: trigLevel = TRIG_F;
    endcase
  end

  assign errSummary = (errCount != '0);
  assign irqLine    = enLine && (((|headErr) && !headAck) || overrun);
  assign irqData    = enData && (level >= trigLevel);
  assign irqModem   = enModem && (|modemDelta);

  always_comb begin
    if (irqLine)       irqId = ID_LINE;
    else if (irqData)  irqId = ID_DATA;
    else if (irqModem) irqId = ID_MODEM;
    else               irqId = ID_NONE;
  end
endmodule

// File: rtl/rx_err_queue.sv
module rx_err_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  parameter int ERR_W = 3,
  parameter int MODEM_W = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int WORD_W = DATA_W + ERR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrValid,
  input  logic [DATA_W-1:0]  wrByte,
  input  logic [ERR_W-1:0]   wrErr,
  input  logic               rdData,
  input  logic               rdLsr,
  input  logic               rdMsr,
  input  logic [1:0]         trigSel,
  input  logic               enLine,
  input  logic               enData,
  input  logic               enModem,
  input  logic [MODEM_W-1:0] modemIn,
  output logic [DATA_W-1:0]  rdByte,
  output logic [ERR_W-1:0]   headErr,
  output logic [CNT_W-1:0]   level,
  output logic               errSummary,
  output logic               overrun,
  output logic [MODEM_W-1:0] modemDelta,
  output logic               irqLine,
  output logic               irqData,
  output logic               irqModem,
  output logic [1:0]         irqId
);
  qStrobe_t          strobe;
  logic [WORD_W-1:0] headWord;
  logic              full;
  logic              empty;

  rxq_data #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrWord   ({wrErr, wrByte}),
    .headWord (headWord),
    .level    (level),
    .full     (full),
    .empty    (empty)
  );

  assign rdByte  = empty ? '0 : headWord[DATA_W-1:0];
  assign headErr = empty ? '0 : headWord[WORD_W-1:DATA_W];

  rxq_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W), .MODEM_W(MODEM_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrValid    (wrValid),
    .wrErr      (wrErr),
    .rdData     (rdData),
    .rdLsr      (rdLsr),
    .rdMsr      (rdMsr),
    .trigSel    (trigSel),
    .enLine     (enLine),
    .enData     (enData),
    .enModem    (enModem),
    .modemIn    (modemIn),
    .level      (level),
    .full       (full),
    .empty      (empty),
    .headErr    (headErr),
    .strobe     (strobe),
    .errSummary (errSummary),
    .overrun    (overrun),
    .modemDelta (modemDelta),
    .irqLine    (irqLine),
    .irqData    (irqData),
    .irqModem   (irqModem),
    .irqId      (irqId)
  );
endmodule

// File: rtl/rx_err_queue_chk.sv
module rx_err_queue_chk #(
  parameter int DEPTH = 16,
  parameter int ERR_W = 3,
  parameter int MODEM_W = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrValid,
  input logic               rdData,
  input logic               rdLsr,
  input logic               rdMsr,
  input logic [1:0]         trigSel,
  input logic               enData,
  input logic [MODEM_W-1:0] modemIn,
  input logic [CNT_W-1:0]   level,
  input logic [ERR_W-1:0]   headErr,
  input logic               errSummary,
  input logic               overrun,
  input logic [MODEM_W-1:0] modemDelta,
  input logic               irqLine,
  input logic               irqData,
  input logic [1:0]         irqId
);
  a_r3_head_err_implies_summary: assert property (@(posedge clk) disable iff (!rstN)
    (headErr != '0) |-> errSummary);

  a_r5_lsr_drops_line: assert property (@(posedge clk) disable iff (!rstN)
    (rdLsr && !rdData && !wrValid && level != '0) |=> !irqLine);

  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !rdLsr) |=> overrun);

  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));

  a_r7_single_byte_trigger: assert property (@(posedge clk) disable iff (!rstN)
    (trigSel == 2'd0 && enData && level != '0) |-> irqData);

  a_r8_msr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdMsr && modemIn == $past(modemIn)) |=> (modemDelta == '0));

  a_r9_line_first: assert property (@(posedge clk) disable iff (!rstN)
    irqLine |-> (irqId == 2'd1));
endmodule

bind rx_err_queue rx_err_queue_chk #(.DEPTH(DEPTH), .ERR_W(ERR_W), .MODEM_W(MODEM_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrValid    (wrValid),
  .rdData     (rdData),
  .rdLsr      (rdLsr),
  .rdMsr      (rdMsr),
  .trigSel    (trigSel),
  .enData     (enData),
  .modemIn    (modemIn),
  .level      (level),
  .headErr    (headErr),
  .errSummary (errSummary),
  .overrun    (overrun),
  .modemDelta (modemDelta),
  .irqLine    (irqLine),
  .irqData    (irqData),
  .irqId      (irqId)
);

// File: tb/rx_err_queue_tb.sv
`timescale 1ns/1ps
module rx_err_queue_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrByte = '0;
  logic [2:0] wrErr = '0;
  logic       rdData = 1'b0;
  logic       rdLsr = 1'b0;
  logic       rdMsr = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic       enLine = 1'b1;
  logic       enData = 1'b1;
  logic       enModem = 1'b1;
  logic [3:0] modemIn = '0;
  logic [7:0] rdByte;
  logic [2:0] headErr;
  logic [4:0] level;
  logic       errSummary;
  logic       overrun;
  logic [3:0] modemDelta;
  logic       irqLine;
  logic       irqData;
  logic       irqModem;
  logic [1:0] irqId;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rx_err_queue u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte), .wrErr(wrErr),
    .rdData(rdData), .rdLsr(rdLsr), .rdMsr(rdMsr), .trigSel(trigSel),
    .enLine(enLine), .enData(enData), .enModem(enModem), .modemIn(modemIn),
    .rdByte(rdByte), .headErr(headErr), .level(level), .errSummary(errSummary),
    .overrun(overrun), .modemDelta(modemDelta), .irqLine(irqLine),
    .irqData(irqData), .irqModem(irqModem), .irqId(irqId)
  );

  // Vector: {byte[16:9], err[8:6], expected level[5:1], expected summary[0]}
  localparam logic [16:0] VEC [6] = '{
    {8'h11, 3'b000, 5'd1, 1'b0},
    {8'h22, 3'b000, 5'd2, 1'b0},
    {8'h33, 3'b001, 5'd3, 1'b1},
    {8'h44, 3'b000, 5'd4, 1'b1},
    {8'h55, 3'b010, 5'd5, 1'b1},
    {8'h66, 3'b000, 5'd6, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic [2:0] e);
    @(negedge clk);
    wrValid = 1'b1; wrByte = b; wrErr = e;
    @(negedge clk);
    wrValid = 1'b0; wrErr = '0;
  endtask

  task automatic pop();
    @(negedge clk); rdData = 1'b1;
    @(negedge clk); rdData = 1'b0;
  endtask

  task automatic lsrRead();
    @(negedge clk); rdLsr = 1'b1;
    @(negedge clk); rdLsr = 1'b0;
  endtask

  task automatic msrRead();
    @(negedge clk); rdMsr = 1'b1;
    @(negedge clk); rdMsr = 1'b0;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(level == 0 && rdByte == 0 && headErr == 0 && !errSummary && !overrun &&
          modemDelta == 0 && !irqLine && !irqData && !irqModem && irqId == 0,
          "R1 reset state", {level, irqId}, 0);
    rstN = 1'b1;

    // R2 R3 R4 table of writes: errors behind a clean head
    for (int i = 0; i < 6; i++) begin
      push(VEC[i][16:9], VEC[i][8:6]);
      check(level == VEC[i][5:1], "R2 level after write", level, VEC[i][5:1]);
      check(errSummary == VEC[i][0], "R3 summary after write", errSummary, VEC[i][0]);
      check(!irqLine && rdByte == 8'h11, "R4 clean head keeps line quiet", {irqLine, rdByte}, 8'h11);
    end
    check(irqId == 2'd2, "R9 data id", irqId, 2);

    pop();
    check(rdByte == 8'h22 && headErr == 0, "R2 second entry", rdByte, 8'h22);
    pop();
    check(rdByte == 8'h33 && headErr == 3'b001, "R2 parity tag at head", {headErr, rdByte}, {3'b001, 8'h33});
    check(irqLine, "R4 errored head raises line", irqLine, 1);
    check(irqId == 2'd1, "R9 line over data", irqId, 1);
    lsrRead();
    check(!irqLine && headErr == 3'b001, "R5 lsr read drops line", {irqLine, headErr}, 3'b001);
    check(errSummary, "R3 summary with errored head", errSummary, 1);
    pop();
    check(rdByte == 8'h44 && !irqLine && errSummary, "R3 framing byte still queued", {irqLine, errSummary}, 1);
    pop();
    check(irqLine && headErr == 3'b010, "R5 next errored head rearms", {irqLine, headErr}, {1'b1, 3'b010});
    pop();
    check(!errSummary && !irqLine && rdByte == 8'h66, "R3 summary clears", errSummary, 0);
    pop();
    check(level == 0 && rdByte == 0, "R2 drained", level, 0);

    // R10 pop on empty
    pop();
    check(level == 0, "R10 empty pop level", level, 0);
    push(8'h5A, 3'b100);
    check(level == 1 && rdByte == 8'h5A && headErr == 3'b100, "R10 byte intact after empty pop",
          {headErr, rdByte}, {3'b100, 8'h5A});
    pop();

    // R7 trigger levels
    trigSel = 2'd1;
    for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i), 3'b000);
    check(!irqData, "R7 below four", irqData, 0);
    push(8'hA3, 3'b000);
    check(irqData, "R7 reaches four", irqData, 1);
    trigSel = 2'd2;
    #0.1;
    check(!irqData, "R7 below eight", irqData, 0);
    trigSel = 2'd3;
    for (int i = 4; i < 13; i++) push(8'hA0 + 8'(i), 3'b000);
    check(level == 13 && !irqData, "R7 thirteen below fourteen", {level, irqData}, {5'd13, 1'b0});
    push(8'hAD, 3'b000);
    check(irqData, "R7 reaches fourteen", irqData, 1);
    push(8'hAE, 3'b000);
    push(8'hAF, 3'b000);

    // R6 overflow
    check(!overrun && level == 16, "R6 full no overrun", {level, overrun}, {5'd16, 1'b0});
    push(8'hEE, 3'b111);
    check(level == 16 && overrun && irqLine && !errSummary, "R6 dropped write",
          {level, overrun, irqLine}, {5'd16, 1'b1, 1'b1});
    repeat (3) @(negedge clk);
    check(overrun, "R6 overrun sticky", overrun, 1);
    lsrRead();
    check(!overrun && !irqLine, "R6 lsr clears overrun", {overrun, irqLine}, 0);
    for (int i = 0; i < 15; i++) pop();
    check(level == 1 && rdByte == 8'hAF, "R6 last kept byte", rdByte, 8'hAF);

    // R8 modem change detection
    @(negedge clk); modemIn = 4'b0100;
    @(negedge clk);
    check(modemDelta == 4'b0100 && irqModem, "R8 delta latched", modemDelta, 4'b0100);
    check(irqId == 2'd3, "R9 modem id", irqId, 3);
    repeat (2) @(negedge clk);
    check(modemDelta == 4'b0100, "R8 delta holds", modemDelta, 4'b0100);
    trigSel = 2'd0;
    #0.1;
    check(irqId == 2'd2, "R9 data over modem", irqId, 2);
    msrRead();
    check(modemDelta == 0 && !irqModem, "R8 msr clears", modemDelta, 0);

    // R1 flush with content
    @(negedge clk); modemIn = 4'b0000;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(level == 0 && modemDelta == 0 && irqId == 0 && rdByte == 0, "R1 flush on reset",
          {level, modemDelta}, 0);
    rstN = 1'b1;
    @(negedge clk);
    finish();
  end
endmodule